// File: doc/BRIEF.md
# Comparator Output Conditioner

This block cleans up the single-bit decision of an analog comparator before logic uses it. The raw level is brought into the clock domain through a synchronizer chain and optionally inverted. It then passes through a digital filter. The filter length is set as a count of clock cycles, and the filter can run in one of four modes or be bypassed entirely. The conditioned level is available as an output pin.

Each rising or falling transition of the conditioned level sets a sticky status flag, and software clears a flag by writing 1 to it. Two independent mask registers turn those flags into an interrupt request and a DMA request. Software reaches all of this through a small word-wide write port and a combinational read port, with four word addresses.

Top module: `cmpout_conditioner`

## Requirements
- R1: After reset, the conditioned output, both requests, and every register read back 0.
- R2: With filtering off, a new input level appears on `filt_out` on the third rising clock edge after it is applied: two synchronizer stages plus the output register.
- R3: Control word (address 0) bit 16 inverts the synchronized input when set to 1 and leaves it unchanged when set to 0.
- R4: Control bit 17 forces bypass behaviour whatever the mode field (bits 14:12) and the length field (bits 11:0) hold.
- R5: Mode code 000 means bypass. The unlisted codes 001, 010 and 011 behave as bypass too.
- R6: Mode 100 (immediate): the output takes a new level on the first cycle it differs, then holds for length cycles and ignores the input during that time.
- R7: Mode 101 (qualified): the output changes only on the length-th consecutive cycle that shows the new level. A return to the old level restarts the count.
- R8: Mode 110: a fall to 0 passes at once, while a rise must be qualified as in R7.
- R9: Mode 111: a rise to 1 passes at once, while a fall must be qualified as in R7.
- R10: Status (address 1) bit 0 records a rise of `filt_out` and bit 1 records a fall. A flag is set one cycle after the output changes, stays set, and is cleared by writing 1 to it. Writing 0 to a flag leaves it unchanged.
- R11: If a write-1-to-clear and a new event for the same flag arrive in the same cycle, the flag ends set.
- R12: `irq_req` is the OR of the status flags masked by address 2, and `dma_req` is the OR masked by address 3. In both masks, bit 0 is the rise flag and bit 1 the fall flag.
- R13: While control bit 20 (enable) is 0, no flag is set, although `filt_out` keeps tracking the input. Re-enabling with a steady input sets no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmp_raw | input | 1 | Asynchronous comparator decision |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write word address |
| wr_data | input | 32 | Write data |
| rd_addr | input | 2 | Read word address |
| rd_data | output | 32 | Read data, combinational |
| filt_out | output | 1 | Conditioned comparator level |
| irq_req | output | 1 | Masked interrupt request |
| dma_req | output | 1 | Masked DMA request |

## Verification
The bench samples the output exactly one cycle before and one cycle after the expected transition in every mode. A counter that is off by one, or a filter that skips the synchronizer delay, therefore shows up as a mismatch.

A three-cycle glitch is applied against a length of five. A design that does not restart the count on a glitch would let that glitch through. A change is also applied inside the immediate-mode hold-off window, and a filter without a hold-off would follow it early.

The clear write is placed on the exact edge where a new rise event arrives. A design where clearing wins would lose that event. Finally, the channel is disabled while the output toggles and then re-enabled with a steady input. A design that does not keep tracking the previous output while disabled would report a false edge after re-enabling.

// File: rtl/cmpflt_pkg.sv
package cmpflt_pkg;
   // word addresses of the register port
   localparam logic [1:0] A_CTRL = 2'd0;
   localparam logic [1:0] A_STAT = 2'd1;
   localparam logic [1:0] A_IRQM = 2'd2;
   localparam logic [1:0] A_DMAM = 2'd3;

   // control word layout
   localparam int unsigned LEN_MAX_W = 12;
   localparam int unsigned MODE_LSB  = 12;
   localparam int unsigned INV_BIT   = 16;
   localparam int unsigned BYP_BIT   = 17;
   localparam int unsigned EN_BIT    = 20;

   // filter mode codes
   localparam logic [2:0] FM_BYPASS = 3'b000;
   localparam logic [2:0] FM_IMMED  = 3'b100;
   localparam logic [2:0] FM_QUAL   = 3'b101;
   localparam logic [2:0] FM_LOWB   = 3'b110;
   localparam logic [2:0] FM_HIGHB  = 3'b111;

   localparam int unsigned N_EVT = 2;  // bit 0 rise, bit 1 fall
endpackage

// File: rtl/cmpflt_sync.sv
module cmpflt_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   generate
      if (STAGES < 2) begin : g_bad_depth
         $error("cmpflt_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/cmpflt_core.sv
module cmpflt_core
   import cmpflt_pkg::*;
#(
   parameter int unsigned LEN_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             p,
   input  logic [LEN_W-1:0] len,
   input  logic [2:0]       mode,
   input  logic             byp,
   output logic             f
);
   logic [LEN_W-1:0] cnt, cnt_n;
   logic [LEN_W:0]   cnt_inc;
   logic             f_n, hit;

   assign cnt_inc = {1'b0, cnt} + 1'b1;
   assign hit     = cnt_inc >= {1'b0, len};

   always_comb begin
      f_n   = f;
      cnt_n = cnt;
      if (byp) begin
         f_n   = p;
         cnt_n = '0;
      end else begin
         unique case (mode)
            FM_IMMED: begin
               if (cnt != '0) cnt_n = cnt - 1'b1;
               else if (p != f) begin
                  f_n   = p;
                  cnt_n = len;
               end
            end
            FM_QUAL, FM_LOWB, FM_HIGHB: begin
               if ((mode == FM_LOWB && !p && f) || (mode == FM_HIGHB && p && !f)) begin
                  f_n   = p;
                  cnt_n = '0;
               end else if (p == f) begin
                  cnt_n = '0;
               end else if (hit) begin
                  f_n   = p;
                  cnt_n = '0;
               end else begin
                  cnt_n = cnt_inc[LEN_W-1:0];
               end
            end
            default: begin
               f_n   = p;
               cnt_n = '0;
            end
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         f   <= 1'b0;
         cnt <= '0;
      end else begin
         f   <= f_n;
         cnt <= cnt_n;
      end
   end

   // the output can only ever move to the level the filter just sampled
   p_moves_to_input_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(f) |-> (f == $past(p)));

   // immediate mode holds while the hold-off count is running
   p_holdoff_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!byp && mode == FM_IMMED && cnt != '0) |=> $stable(f));
endmodule

// File: rtl/cmpflt_events.sv
module cmpflt_events
   import cmpflt_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             f,
   input  logic [N_EVT-1:0] clr,
   input  logic [N_EVT-1:0] irq_m,
   input  logic [N_EVT-1:0] dma_m,
   output logic [N_EVT-1:0] flags,
   output logic             irq,
   output logic             dma
);
   logic             f_d;
   logic [N_EVT-1:0] ev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) f_d <= 1'b0;
      else        f_d <= f;
   end

   assign ev[0] = en &  f & ~f_d;
   assign ev[1] = en & ~f &  f_d;

   generate
      for (genvar i = 0; i < N_EVT; i++) begin : g_flag
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) flags[i] <= 1'b0;
            else        flags[i] <= (flags[i] & ~clr[i]) | ev[i];
         end

         p_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
            (flags[i] && !clr[i]) |=> flags[i]);

         p_needs_enable_r13: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(flags[i]) |-> $past(en));
      end
   endgenerate

   assign irq = |(flags & irq_m);
   assign dma = |(flags & dma_m);

   p_quiet_when_clear_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (flags == '0) |-> (!irq && !dma));
endmodule

// File: rtl/cmpout_conditioner.sv
module cmpout_conditioner
   import cmpflt_pkg::*;
#(
   parameter int unsigned LEN_W       = 12,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned DATA_W      = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmp_raw,
   input  logic              wr_en,
   input  logic [1:0]        wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [1:0]        rd_addr,
   output logic [DATA_W-1:0] rd_data,
   output logic              filt_out,
   output logic              irq_req,
   output logic              dma_req
);
   generate
      if (LEN_W < 1 || LEN_W > LEN_MAX_W) begin : g_bad_len
         $error("cmpout_conditioner: LEN_W out of range");
      end
      if (DATA_W <= EN_BIT) begin : g_bad_data
         $error("cmpout_conditioner: DATA_W too narrow for control word");
      end
   endgenerate

   logic [LEN_W-1:0] len_q;
   logic [2:0]       mode_q;
   logic             inv_q, byp_q, en_q;
   logic [N_EVT-1:0] irqm_q, dmam_q, flags, clr;
   logic             s_cmp, p_cmp;
   logic             wr_ctrl;

   assign wr_ctrl = wr_en && (wr_addr == A_CTRL);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         len_q  <= '0;
         mode_q <= FM_BYPASS;
         inv_q  <= 1'b0;
         byp_q  <= 1'b0;
         en_q   <= 1'b0;
         irqm_q <= '0;
         dmam_q <= '0;
      end else begin
         if (wr_ctrl) begin
            len_q  <= wr_data[LEN_W-1:0];
            mode_q <= wr_data[MODE_LSB +: 3];
            inv_q  <= wr_data[INV_BIT];
            byp_q  <= wr_data[BYP_BIT];
            en_q   <= wr_data[EN_BIT];
         end
         if (wr_en && wr_addr == A_IRQM) irqm_q <= wr_data[N_EVT-1:0];
         if (wr_en && wr_addr == A_DMAM) dmam_q <= wr_data[N_EVT-1:0];
      end
   end

   assign clr = (wr_en && wr_addr == A_STAT) ? wr_data[N_EVT-1:0] : '0;

   always_comb begin
      rd_data = '0;
      unique case (rd_addr)
         A_CTRL: begin
            rd_data[LEN_W-1:0]     = len_q;
            rd_data[MODE_LSB +: 3] = mode_q;
            rd_data[INV_BIT]       = inv_q;
            rd_data[BYP_BIT]       = byp_q;
            rd_data[EN_BIT]        = en_q;
         end
         A_STAT:  rd_data[N_EVT-1:0] = flags;
         A_IRQM:  rd_data[N_EVT-1:0] = irqm_q;
         default: rd_data[N_EVT-1:0] = dmam_q;
      endcase
   end

   cmpflt_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(cmp_raw), .q(s_cmp)
   );

   assign p_cmp = s_cmp ^ inv_q;

   cmpflt_core #(.LEN_W(LEN_W)) u_core (
      .clk(clk), .rst_n(rst_n), .p(p_cmp), .len(len_q),
      .mode(mode_q), .byp(byp_q), .f(filt_out)
   );

   cmpflt_events u_evt (
      .clk(clk), .rst_n(rst_n), .en(en_q), .f(filt_out), .clr(clr),
      .irq_m(irqm_q), .dma_m(dmam_q), .flags(flags),
      .irq(irq_req), .dma(dma_req)
   );
endmodule

// File: tb/cmpout_conditioner_test.sv
module cmpout_conditioner_test;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmp_raw = 1'b0;
   logic        wr_en = 1'b0;
   logic [1:0]  wr_addr = '0;
   logic [31:0] wr_data = '0;
   logic [1:0]  rd_addr = '0;
   logic [31:0] rd_data;
   logic        filt_out, irq_req, dma_req;

   int n_chk = 0;
   int n_bad = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   cmpout_conditioner uut (
      .clk(clk), .rst_n(rst_n), .cmp_raw(cmp_raw),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .rd_data(rd_data),
      .filt_out(filt_out), .irq_req(irq_req), .dma_req(dma_req)
   );

   function automatic logic [31:0] ctl(input logic en, input logic byp,
                                       input logic inv, input logic [2:0] mode,
                                       input logic [11:0] len);
      return (32'(en) << 20) | (32'(byp) << 17) | (32'(inv) << 16) |
             (32'(mode) << 12) | 32'(len);
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic adv(input int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic wr(input logic [1:0] a, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [31:0] v);
      rd_addr = a;
      #1;
      v = rd_data;
   endtask

   task automatic setup(input logic [31:0] c);
      wr(2'd0, c);
      adv(20);
      wr(2'd1, 32'h3);
   endtask

   task automatic t_reset();
      logic [31:0] v;
      rd(2'd0, v); chk("R1 ctrl", v, 0);
      rd(2'd1, v); chk("R1 status", v, 0);
      rd(2'd2, v); chk("R1 irq mask", v, 0);
      chk("R1 filt_out", filt_out, 0);
      chk("R1 irq_req", irq_req, 0);
      chk("R1 dma_req", dma_req, 0);
   endtask

   task automatic t_bypass();
      setup(ctl(1, 0, 0, 3'b000, 0));
      cmp_raw = 1'b1;
      adv(2); chk("R2 before third edge", filt_out, 0);
      adv(1); chk("R2 third edge", filt_out, 1);
      setup(ctl(1, 0, 0, 3'b010, 40));
      cmp_raw = 1'b0;
      adv(2); chk("R5 unlisted early", filt_out, 1);
      adv(1); chk("R5 unlisted mode bypasses", filt_out, 0);
   endtask

   task automatic t_polarity();
      setup(ctl(1, 0, 1, 3'b000, 0));
      chk("R3 inverted low", filt_out, 1);
      cmp_raw = 1'b1;
      adv(3); chk("R3 inverted high", filt_out, 0);
   endtask

   task automatic t_bypass_bit();
      setup(ctl(1, 1, 0, 3'b101, 50));
      chk("R4 settle", filt_out, 1);
      cmp_raw = 1'b0;
      adv(3); chk("R4 bypass bit overrides mode", filt_out, 0);
   endtask

   task automatic t_qualified();
      setup(ctl(1, 0, 0, 3'b101, 5));
      cmp_raw = 1'b1;
      adv(3);
      cmp_raw = 1'b0;
      adv(10); chk("R7 glitch rejected", filt_out, 0);
      cmp_raw = 1'b1;
      adv(6); chk("R7 not yet qualified", filt_out, 0);
      adv(1); chk("R7 qualified change", filt_out, 1);
   endtask

   task automatic t_immediate();
      setup(ctl(1, 0, 0, 3'b100, 6));
      cmp_raw = 1'b0;
      adv(3); chk("R6 immediate change", filt_out, 0);
      cmp_raw = 1'b1;
      adv(6); chk("R6 hold-off ignores input", filt_out, 0);
      adv(1); chk("R6 change after hold-off", filt_out, 1);
   endtask

   task automatic t_stable_low();
      setup(ctl(1, 0, 0, 3'b110, 5));
      cmp_raw = 1'b0;
      adv(2); chk("R8 fall early", filt_out, 1);
      adv(1); chk("R8 fall passes at once", filt_out, 0);
      cmp_raw = 1'b1;
      adv(6); chk("R8 rise held", filt_out, 0);
      adv(1); chk("R8 rise qualified", filt_out, 1);
   endtask

   task automatic t_stable_high();
      setup(ctl(1, 0, 0, 3'b111, 5));
      cmp_raw = 1'b0;
      adv(6); chk("R9 fall held", filt_out, 1);
      adv(1); chk("R9 fall qualified", filt_out, 0);
      cmp_raw = 1'b1;
      adv(2); chk("R9 rise early", filt_out, 0);
      adv(1); chk("R9 rise passes at once", filt_out, 1);
   endtask

   task automatic t_flags();
      logic [31:0] v;
      setup(ctl(1, 0, 0, 3'b000, 0));
      wr(2'd2, 32'h1);
      wr(2'd3, 32'h2);
      cmp_raw = 1'b0;
      adv(10);
      wr(2'd1, 32'h3);
      rd(2'd1, v); chk("R10 cleared", v, 0);
      cmp_raw = 1'b1;
      adv(3); rd(2'd1, v); chk("R10 not set before output edge", v, 0);
      adv(1); rd(2'd1, v); chk("R10 rise flag", v, 1);
      chk("R12 irq from rise", irq_req, 1);
      chk("R12 dma masked", dma_req, 0);
      cmp_raw = 1'b0;
      adv(4); rd(2'd1, v); chk("R10 both flags sticky", v, 3);
      chk("R12 dma from fall", dma_req, 1);
      wr(2'd1, 32'h1);
      rd(2'd1, v); chk("R10 clear rise only", v, 2);
      chk("R12 irq drops", irq_req, 0);
      wr(2'd1, 32'h2);
      rd(2'd1, v); chk("R10 clear fall", v, 0);
      chk("R12 dma drops", dma_req, 0);
   endtask

   task automatic t_collide();
      logic [31:0] v;
      cmp_raw = 1'b1;
      adv(3);
      wr_en = 1'b1; wr_addr = 2'd1; wr_data = 32'h1;
      @(negedge clk);
      wr_en = 1'b0;
      rd(2'd1, v); chk("R11 set wins over clear", v, 1);
      wr(2'd1, 32'h1);
      rd(2'd1, v); chk("R11 later clear works", v, 0);
   endtask

   task automatic t_disable();
      logic [31:0] v;
      setup(ctl(0, 0, 0, 3'b000, 0));
      cmp_raw = 1'b0;
      adv(4); chk("R13 output tracks while off", filt_out, 0);
      rd(2'd1, v); chk("R13 no fall flag while off", v, 0);
      cmp_raw = 1'b1;
      adv(4); rd(2'd1, v); chk("R13 no rise flag while off", v, 0);
      wr(2'd0, ctl(1, 0, 0, 3'b000, 0));
      adv(5); rd(2'd1, v); chk("R13 no spurious flag on enable", v, 0);
      cmp_raw = 1'b0;
      adv(4); rd(2'd1, v); chk("R13 flags after enable", v, 2);
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_bypass();
      t_polarity();
      t_bypass_bit();
      t_qualified();
      t_immediate();
      t_stable_low();
      t_stable_high();
      t_flags();
      t_collide();
      t_disable();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule